// File: doc/BRIEF.md
# Two-Bit Equation-Driven Sequence Machine

This block is a clocked Moore machine with one serial input bit, two state bits and one output bit. The next-state behaviour is fixed by two Boolean drive terms: the drive for the upper state bit is the input OR the lower state bit, and the drive for the lower state bit is the input AND the upper state bit. The output is high only in the state where both bits are set.

A build-time parameter chooses how the two drive terms reach storage. In load style each drive term is the next value of its bit. In toggle style each bit flips whenever its drive term is 1 and holds otherwise. The same drive logic therefore gives two different transition tables, so one netlist of gates can serve as either of two sequence recognisers.

The present state is visible as a two-bit code and as a one-hot state-name trace for debug. Reset is synchronous and active low, and it returns the machine to its idle state in both styles.

Top module: `eqfsm_core`

## Requirements
- R1: When rst_n is sampled low at a rising clock edge, the state becomes S0 (q_state = 2'b00), y_out becomes 0 and state_onehot becomes 4'b0001 after that edge.
- R2: y_out is 1 exactly when q_state is 2'b11 (S3), and it depends on the present state only, not on x_in.
- R3: In load style, at each rising edge with rst_n high, the new q_state[1] equals x_in OR the old q_state[0].
- R4: In load style, at each rising edge with rst_n high, the new q_state[0] equals x_in AND the old q_state[1].
- R5: In toggle style, at each rising edge with rst_n high, q_state[1] inverts when x_in OR the old q_state[0] is 1, and holds otherwise.
- R6: In toggle style, at each rising edge with rst_n high, q_state[0] inverts when x_in AND the old q_state[1] is 1, and holds otherwise.
- R7: The state codes, written as q_state[1:0], are S0 = 00, S1 = 01, S2 = 10 and S3 = 11. state_onehot has exactly one bit set, and bit i is set when the machine is in Si.
- R8: In toggle style, starting in S0 and applying x_in = 0, 1, 1, 0, 1 on successive edges gives the states S0, S2, S1, S3, S0 after each edge.
- R9: Boundary transitions: in load style, S2 goes to S3 when x_in = 1 and to S0 when x_in = 0. In toggle style, S3 goes to S1 when x_in = 0 and to S0 when x_in = 1.
- R10: Reset has priority over the input. With rst_n low, the state goes to S0 whatever the value of x_in and the present state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x_in | input | 1 | Serial input bit, sampled at each rising edge |
| q_state | output | 2 | Present state code, upper bit first |
| y_out | output | 1 | Moore output, high in S3 |
| state_onehot | output | 4 | Trace of the present state name, bit i for Si |

## Verification
The bench builds one instance of each storage style, drives both from the same stream and compares them with separate bench models at every edge. Toggle style is the most likely place for an error. A design that loaded the drive terms instead of XORing them with the present state would still look correct on a few transitions, so the bench runs the full directed toggle sequence and the S3 exits, where load and toggle styles disagree. Reset is asserted in the middle of a run with the input held at 1 and from S3. A reset that lost priority to the input, or one that only cleared one bit, would leave the machine outside S0. Random streams cover every state and input pair many times, so a swapped drive term or a wrong output decode appears as a mismatch on y_out or on the trace.

// File: rtl/eqfsm_pkg.sv
// Package: shared widths, state codes and the storage-style selector for the
// two-bit equation-driven machine. Assumes state codes equal state indices.
package eqfsm_pkg;

    localparam int STATE_W   = 2;
    localparam int NUM_STATE = 1 << STATE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_S0 = 2'b00,
        ST_S1 = 2'b01,
        ST_S2 = 2'b10,
        ST_S3 = 2'b11
    } state_e;

    typedef enum logic {
        STORE_LOAD   = 1'b0,
        STORE_TOGGLE = 1'b1
    } store_e;

endpackage

// File: rtl/eqfsm_drive_logic.sv
// Module: eqfsm_drive_logic
// Forms the two drive terms from the serial input and the present state.
// Purely combinational; the storage style decides how the terms are used.
module eqfsm_drive_logic
    import eqfsm_pkg::*;
(
    input  logic               x_in,
    input  logic [STATE_W-1:0] q_cur,
    output logic [STATE_W-1:0] drive
);

    // Drive terms: upper = x OR lower bit, lower = x AND upper bit.
    always_comb begin
        drive[1] = x_in | q_cur[0];
        drive[0] = x_in & q_cur[1];
    end

endmodule

// File: rtl/eqfsm_state_store.sv
// Module: eqfsm_state_store
// Holds the state bits. STYLE picks load storage (bit takes its drive) or
// toggle storage (bit inverts when its drive is 1). Assumes the drive vector
// is settled before the rising edge; reset is synchronous and active low.
module eqfsm_state_store
    import eqfsm_pkg::*;
#(
    parameter store_e STYLE = STORE_LOAD
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] drive,
    output logic [STATE_W-1:0] q
);

    generate
        if (STYLE == STORE_LOAD) begin : g_load
            // Load storage: each bit takes its drive term at the edge.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= drive;
            end

            // R3: new upper bit equals the drive presented before the edge
            assert_load_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> q[1] == $past(drive[1]));
            // R4: new lower bit equals the drive presented before the edge
            assert_load_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> q[0] == $past(drive[0]));
        end else begin : g_toggle
            // Toggle storage: each bit inverts when its drive term is 1.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= q ^ drive;
            end

            // R5: upper bit changes exactly when its drive was 1
            assert_toggle_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (q[1] != $past(q[1])) == $past(drive[1]));
            // R6: lower bit changes exactly when its drive was 1
            assert_toggle_lower_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (q[0] != $past(q[0])) == $past(drive[0]));
        end
    endgenerate

    // R1 / R10: a low reset sample clears the state whatever the drive
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> q == '0);

endmodule

// File: rtl/eqfsm_state_decode.sv
// Module: eqfsm_state_decode
// Decodes the present state into the Moore output and a one-hot state-name
// trace. Combinational; clk and rst_n are used only by its checks.
module eqfsm_state_decode
    import eqfsm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [STATE_W-1:0]   q_cur,
    output logic                 y_out,
    output logic [NUM_STATE-1:0] state_onehot
);

    // Moore output: high only when both state bits are set.
    always_comb y_out = q_cur[1] & q_cur[0];

    // One trace bit per state code.
    generate
        for (genvar i = 0; i < NUM_STATE; i++) begin : g_trace
            assign state_onehot[i] = (q_cur == STATE_W'(i));
        end
    endgenerate

    // R7: trace names exactly one state
    assert_trace_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_onehot) == 1);
    // R2: output agrees with the S3 trace bit
    assert_output_s3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        y_out == state_onehot[ST_S3]);

endmodule

// File: rtl/eqfsm_core.sv
// Module: eqfsm_core (top)
// Two-bit Moore machine with equation-defined drive terms realised on load or
// toggle storage, chosen by STYLE. Assumes x_in is already synchronous to clk.
module eqfsm_core
    import eqfsm_pkg::*;
#(
    parameter store_e STYLE = STORE_LOAD
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 x_in,
    output logic [STATE_W-1:0]   q_state,
    output logic                 y_out,
    output logic [NUM_STATE-1:0] state_onehot
);

    logic [STATE_W-1:0] drive;

    // Drive terms from input and present state.
    eqfsm_drive_logic u_drive (
        .x_in  (x_in),
        .q_cur (q_state),
        .drive (drive)
    );

    // State storage in the selected style.
    eqfsm_state_store #(.STYLE(STYLE)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .drive (drive),
        .q     (q_state)
    );

    // Output and trace decode.
    eqfsm_state_decode u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_cur        (q_state),
        .y_out        (y_out),
        .state_onehot (state_onehot)
    );

endmodule

// File: tb/eqfsm_core_bench.sv
// Bench: one load-style and one toggle-style instance driven by the same
// stream, each compared with its own bench model after every edge.
module eqfsm_core_bench;
    import eqfsm_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x_in = 1'b0;
    logic [1:0] q_d, q_t;
    logic       y_d, y_t;
    logic [3:0] oh_d, oh_t;
    logic [1:0] exp_d, exp_t;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    eqfsm_core #(.STYLE(STORE_LOAD)) u_eqfsm_core (
        .clk (clk), .rst_n (rst_n), .x_in (x_in),
        .q_state (q_d), .y_out (y_d), .state_onehot (oh_d)
    );

    eqfsm_core #(.STYLE(STORE_TOGGLE)) u_eqfsm_core_t (
        .clk (clk), .rst_n (rst_n), .x_in (x_in),
        .q_state (q_t), .y_out (y_t), .state_onehot (oh_t)
    );

    // Load-style model: R3, R4
    function automatic logic [1:0] next_load(logic [1:0] s, logic x);
        return {x | s[0], x & s[1]};
    endfunction

    // Toggle-style model: R5, R6
    function automatic logic [1:0] next_toggle(logic [1:0] s, logic x);
        return {s[1] ^ (x | s[0]), s[0] ^ (x & s[1])};
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare both instances with their models (R2, R7 on every step).
    task automatic compare_all(string tag);
        check({tag, " load state"},   {2'b0, q_d}, {2'b0, exp_d});
        check({tag, " toggle state"}, {2'b0, q_t}, {2'b0, exp_t});
        check("R2 load y",   {3'b0, y_d}, {3'b0, exp_d == 2'b11});
        check("R2 toggle y", {3'b0, y_t}, {3'b0, exp_t == 2'b11});
        check("R7 load trace",   oh_d, 4'b1 << exp_d);
        check("R7 toggle trace", oh_t, 4'b1 << exp_t);
    endtask

    // One clock with input x; inputs change at the falling edge.
    task automatic step(logic x, string tag);
        @(negedge clk);
        x_in = x;
        rst_n = 1'b1;
        exp_d = next_load(exp_d, x);
        exp_t = next_toggle(exp_t, x);
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    // One clock with reset low and input x (R1, R10).
    task automatic do_reset(logic x, string tag);
        @(negedge clk);
        rst_n = 1'b0;
        x_in = x;
        exp_d = 2'b00;
        exp_t = 2'b00;
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_0042);
        exp_d = 2'b00;
        exp_t = 2'b00;

        // R1: reset state
        do_reset(1'b0, "R1 reset");
        do_reset(1'b1, "R1 R10 reset x=1");

        // R8: directed toggle sequence 0,1,1,0,1 from S0
        step(1'b0, "R8 seq0"); check("R8 after 0", {2'b0, q_t}, 4'h0);
        step(1'b1, "R8 seq1"); check("R8 after 1", {2'b0, q_t}, 4'h2);
        step(1'b1, "R8 seq2"); check("R8 after 1", {2'b0, q_t}, 4'h1);
        step(1'b0, "R8 seq3"); check("R8 after 0", {2'b0, q_t}, 4'h3);
        step(1'b1, "R8 seq4"); check("R8 after 1", {2'b0, q_t}, 4'h0);

        // R9: load style S2 exits
        do_reset(1'b0, "R1 reset");
        step(1'b1, "R9 to S2"); check("R9 load at S2", {2'b0, q_d}, 4'h2);
        step(1'b1, "R9 S2 x1"); check("R9 load S2 x=1", {2'b0, q_d}, 4'h3);
        do_reset(1'b1, "R10 reset from S3");
        step(1'b1, "R9 to S2"); check("R9 load at S2", {2'b0, q_d}, 4'h2);
        step(1'b0, "R9 S2 x0"); check("R9 load S2 x=0", {2'b0, q_d}, 4'h0);

        // R9: toggle style S3 exits
        do_reset(1'b0, "R1 reset");
        step(1'b1, "R9 t"); step(1'b1, "R9 t"); step(1'b0, "R9 t");
        check("R9 toggle at S3", {2'b0, q_t}, 4'h3);
        step(1'b0, "R9 S3 x0"); check("R9 toggle S3 x=0", {2'b0, q_t}, 4'h1);
        step(1'b0, "R9 t");     check("R9 toggle back S3", {2'b0, q_t}, 4'h3);
        step(1'b1, "R9 S3 x1"); check("R9 toggle S3 x=1", {2'b0, q_t}, 4'h0);

        // R3-style random streams with occasional reset (R10)
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 97) == 0) do_reset(1'($urandom), "R10 random reset");
            else                      step(1'($urandom), "R3 R5 random");
        end
        // R4/R6 biased streams: long runs of ones and zeros
        for (int i = 0; i < 1000; i++) begin
            step((($urandom % 8) != 0) ? 1'b1 : 1'b0, "R4 R6 biased");
        end

        finished = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
        end
    end

endmodule